// File: doc/BRIEF.md
# Control Register Write Guard

This block holds the 8-bit control register of a serial non-volatile memory and decides, for every decoded data byte the bus front end delivers, whether that byte is accepted. A byte aimed at the control register can move the two volatile write latches (write-enable and register-write-enable) or load the six non-volatile fields: lock-enable, two watchdog-period bits, two block-protect bits and the reset-period bit. A byte aimed at the array is checked against the write latch and against the block-protect setting. The accept result drives the acknowledge of that byte, and a separate strobe tells the write-cycle sequencer to begin a non-volatile register update.

The front end presents one byte per `wr_valid` cycle. With it come a flag that says whether the byte targets the register, a flag that marks the first data byte of a transaction, the array address, the hardware lock pin level and a busy input from the write-cycle timer. Both decisions come out registered one clock later. The packed register value is always visible for read-back.

Top module: `ctrl_guard_top`

## Requirements
- R1: After reset the read-back value is 00h: both latches clear and every non-volatile field at its reset parameter (default 0). The bit layout from bit 7 down is lock-enable, watchdog[1:0], block-protect[1:0], register-write-enable, write-enable, reset-period.
- R2: While write-enable is 0, every array byte is refused (no acknowledge) and the read-back value does not change.
- R3: A first register byte with bit 1 = 1, with register-write-enable clear, sets write-enable, copies bit 2 into register-write-enable, is acknowledged, starts no non-volatile cycle and leaves the non-volatile fields unchanged (02h sets write-enable only, 06h sets both).
- R4: With register-write-enable set, a first register byte with bit 2 = 0 and bit 1 = 1 loads bits 7, 6, 5, 4, 3 and 0 into the non-volatile fields, clears register-write-enable, keeps write-enable, is acknowledged and pulses the non-volatile start strobe. The sequence 02h, 06h, 02h therefore zeroes all non-volatile fields.
- R5: With register-write-enable set, a register byte with bits 2 and 1 both 1 is acknowledged and changes nothing (02h, 06h, 06h keeps the fields).
- R6: A first register byte with bit 1 = 0 clears both latches and is not acknowledged.
- R7: Block-protect 00 guards nothing, 01 guards the top quarter of the array, 10 the top half and 11 all of it; an array byte at a guarded address is refused and clears register-write-enable, an unguarded one is acknowledged when write-enable is set.
- R8: While the lock pin is high and lock-enable is 1, a non-volatile register load keeps lock-enable and block-protect at their old values; the watchdog and reset-period fields still load.
- R9: A register byte that is not the first data byte of its transaction is not acknowledged and has no effect.
- R10: While busy is high every byte is refused and no state changes.
- R11: Acknowledge and start strobe are single-cycle pulses that appear exactly one clock after the accepted byte, and are low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A decoded data byte is present this cycle |
| wr_to_reg | input | 1 | 1: byte targets the control register, 0: the array |
| wr_first | input | 1 | Byte is the first data byte of its transaction |
| wr_addr | input | ADDR_W (15) | Array byte address |
| wr_data | input | 8 | Data byte |
| lock_pin | input | 1 | Hardware lock pin level |
| busy_in | input | 1 | Non-volatile write cycle in progress |
| wr_ack | output | 1 | Byte accepted, acknowledge it |
| nv_start | output | 1 | Begin a non-volatile register cycle |
| reg_rd | output | 8 | Packed control register value |

## Verification
Every decision is registered, so the acknowledge, the start strobe and the updated read-back value all belong to the first rising edge after the cycle in which `wr_valid` was driven. The driver stamps each expected item with that edge's index and the monitor, sampling shortly after each falling edge, compares an item only when the edge counter equals its stamp; on every other cycle it requires both strobes to be low. Sequences walk the latch protocol, each protection quadrant on both sides of its boundary, the lock pin with lock-enable set and cleared, busy and non-first bytes.

// File: rtl/ctrl_guard_pkg.sv
package ctrl_guard_pkg;

  typedef struct packed {
    logic       lock_en;
    logic [1:0] wdog;
    logic [1:0] prot;
    logic       rst_len;
  } nv_fields_t;

  localparam int unsigned REG_W = 8;

  function automatic logic [REG_W-1:0] pack_reg(input nv_fields_t nv,
                                                input logic rwe,
                                                input logic we);
    return {nv.lock_en, nv.wdog, nv.prot, rwe, we, nv.rst_len};
  endfunction

  function automatic nv_fields_t unpack_nv(input logic [REG_W-1:0] v);
    nv_fields_t f;
    f.lock_en = v[7];
    f.wdog    = v[6:5];
    f.prot    = v[4:3];
    f.rst_len = v[0];
    return f;
  endfunction

endpackage

// File: rtl/ctrl_guard_region.sv
module ctrl_guard_region #(
  parameter int unsigned ADDR_W = 15
) (
  input  logic [1:0]        prot_sel,
  input  logic [ADDR_W-1:0] addr,
  output logic              guarded
);

  localparam int unsigned TOP = ADDR_W - 1;

  logic in_top_half;
  logic in_top_quarter;

  assign in_top_half    = addr[TOP];
  assign in_top_quarter = addr[TOP] & addr[TOP-1];

  always_comb begin
    unique case (prot_sel)
      2'b00:   guarded = 1'b0;
      2'b01:   guarded = in_top_quarter;
      2'b10:   guarded = in_top_half;
      default: guarded = 1'b1;
    endcase
  end

endmodule

// File: rtl/ctrl_guard_decide.sv
module ctrl_guard_decide
  import ctrl_guard_pkg::*;
(
  input  logic       wr_valid,
  input  logic       wr_to_reg,
  input  logic       wr_first,
  input  logic [7:0] wr_data,
  input  logic       lock_pin,
  input  logic       busy_in,
  input  logic       guarded,
  input  logic       we_q,
  input  logic       rwe_q,
  input  nv_fields_t nv_q,
  output logic       we_d,
  output logic       rwe_d,
  output nv_fields_t nv_d,
  output logic       ack_d,
  output logic       start_d
);

  logic       hw_locked;
  nv_fields_t nv_load;

  assign hw_locked = lock_pin & nv_q.lock_en;

  always_comb begin
    nv_load = unpack_nv(wr_data);
    if (hw_locked) begin
      nv_load.lock_en = nv_q.lock_en;
      nv_load.prot    = nv_q.prot;
    end
  end

  always_comb begin
    we_d    = we_q;
    rwe_d   = rwe_q;
    nv_d    = nv_q;
    ack_d   = 1'b0;
    start_d = 1'b0;
    if (wr_valid && !busy_in) begin
      if (wr_to_reg) begin
        if (wr_first) begin
          if (!wr_data[1]) begin
            we_d  = 1'b0;
            rwe_d = 1'b0;
          end else if (rwe_q && !wr_data[2]) begin
            nv_d    = nv_load;
            rwe_d   = 1'b0;
            ack_d   = 1'b1;
            start_d = 1'b1;
          end else begin
            we_d  = 1'b1;
            rwe_d = wr_data[2];
            ack_d = 1'b1;
          end
        end
      end else begin
        if (guarded) begin
          rwe_d = 1'b0;
        end else begin
          ack_d = we_q;
        end
      end
    end
  end

endmodule

// File: rtl/ctrl_guard_top.sv
module ctrl_guard_top
  import ctrl_guard_pkg::*;
#(
  parameter int unsigned ADDR_W   = 15,
  parameter logic [7:0]  NV_RESET = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              wr_to_reg,
  input  logic              wr_first,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              lock_pin,
  input  logic              busy_in,
  output logic              wr_ack,
  output logic              nv_start,
  output logic [7:0]        reg_rd
);

  localparam nv_fields_t NV_INIT = unpack_nv(NV_RESET);

  logic       we_q,  we_d;
  logic       rwe_q, rwe_d;
  nv_fields_t nv_q,  nv_d;
  logic       ack_d, start_d;
  logic       guarded;
  logic       state_en;

  ctrl_guard_region #(.ADDR_W(ADDR_W)) u_region (
    .prot_sel (nv_q.prot),
    .addr     (wr_addr),
    .guarded  (guarded)
  );

  ctrl_guard_decide u_decide (
    .wr_valid  (wr_valid),
    .wr_to_reg (wr_to_reg),
    .wr_first  (wr_first),
    .wr_data   (wr_data),
    .lock_pin  (lock_pin),
    .busy_in   (busy_in),
    .guarded   (guarded),
    .we_q      (we_q),
    .rwe_q     (rwe_q),
    .nv_q      (nv_q),
    .we_d      (we_d),
    .rwe_d     (rwe_d),
    .nv_d      (nv_d),
    .ack_d     (ack_d),
    .start_d   (start_d)
  );

  assign state_en = wr_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q  <= 1'b0;
      rwe_q <= 1'b0;
      nv_q  <= NV_INIT;
    end else if (state_en) begin
      we_q  <= we_d;
      rwe_q <= rwe_d;
      nv_q  <= nv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ack   <= 1'b0;
      nv_start <= 1'b0;
    end else begin
      wr_ack   <= ack_d;
      nv_start <= start_d;
    end
  end

  assign reg_rd = pack_reg(nv_q, rwe_q, we_q);

  // R2: array bytes need the write latch
  p_array_needs_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_to_reg && !we_q) |=> !wr_ack);

  // R4: a register load always comes with an acknowledge and leaves the step latch clear
  p_load_acked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    nv_start |-> (wr_ack && !rwe_q && we_q));

  // R7: full protection refuses every array byte
  p_full_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_to_reg && nv_q.prot == 2'b11) |=> (!wr_ack && !rwe_q));

  // R8: hardware lock holds lock-enable and block-protect
  p_hw_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_pin && nv_q.lock_en) |=> (nv_q.lock_en && nv_q.prot == $past(nv_q.prot)));

  // R9: follow-on register bytes are refused
  p_one_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_to_reg && !wr_first) |=> !wr_ack);

  // R10: busy freezes everything
  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && busy_in) |=> (!wr_ack && !nv_start && $stable(reg_rd)));

  // R11: acknowledge only follows a presented byte
  p_ack_timing_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |-> $past(wr_valid));

endmodule

// File: tb/test_ctrl_guard_top.sv
module test_ctrl_guard_top;

  logic        clk;
  logic        rst_n;
  logic        wr_valid;
  logic        wr_to_reg;
  logic        wr_first;
  logic [14:0] wr_addr;
  logic [7:0]  wr_data;
  logic        lock_pin;
  logic        busy_in;
  logic        wr_ack;
  logic        nv_start;
  logic [7:0]  reg_rd;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 0;

  // bench model of the register, built from the requirements
  logic       m_we, m_rwe, m_lock, m_rst;
  logic [1:0] m_wd, m_bp;

  int          q_due[$];
  logic [9:0]  q_exp[$];
  string       q_tag[$];

  ctrl_guard_top i_ctrl_guard_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_to_reg (wr_to_reg),
    .wr_first  (wr_first),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .lock_pin  (lock_pin),
    .busy_in   (busy_in),
    .wr_ack    (wr_ack),
    .nv_start  (nv_start),
    .reg_rd    (reg_rd)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] m_reg();
    return {m_lock, m_wd, m_bp, m_rwe, m_we, m_rst};
  endfunction

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: ack/start/reg actual %b/%b/%h expected %b/%b/%h",
               tag, act[9], act[8], act[7:0], exp[9], exp[8], exp[7:0]);
    end
  endtask

  task automatic put(input logic to_reg, input logic first, input logic [14:0] addr,
                     input logic [7:0] data, input string tag);
    logic ack, st, guard;
    @(negedge clk);
    wr_valid = 1'b1; wr_to_reg = to_reg; wr_first = first;
    wr_addr = addr; wr_data = data;
    ack = 1'b0; st = 1'b0;
    if (!busy_in) begin
      if (to_reg) begin
        if (first) begin
          if (!data[1]) begin
            m_we = 1'b0; m_rwe = 1'b0;
          end else if (m_rwe && !data[2]) begin
            if (!(lock_pin && m_lock)) begin
              m_lock = data[7]; m_bp = data[4:3];
            end
            m_wd = data[6:5]; m_rst = data[0];
            m_rwe = 1'b0; ack = 1'b1; st = 1'b1;
          end else begin
            m_we = 1'b1; m_rwe = data[2]; ack = 1'b1;
          end
        end
      end else begin
        case (m_bp)
          2'b00: guard = 1'b0;
          2'b01: guard = (addr >= 15'h6000);
          2'b10: guard = (addr >= 15'h4000);
          default: guard = 1'b1;
        endcase
        if (guard) m_rwe = 1'b0;
        else ack = m_we;
      end
    end
    q_due.push_back(cyc + 1);
    q_exp.push_back({ack, st, m_reg()});
    q_tag.push_back(tag);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // monitor: compares each item at the edge it is due, idle strobes otherwise
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (q_due.size() > 0 && q_due[0] == cyc) begin
          check(q_tag.pop_front(), {wr_ack, nv_start, reg_rd}, q_exp.pop_front());
          void'(q_due.pop_front());
        end else begin
          check("R11 idle strobes", {wr_ack, nv_start, 8'h00}, 10'h000);
        end
      end
    end
  end

  initial begin
    wait (cyc > 4000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_to_reg = 1'b0; wr_first = 1'b1;
    wr_addr = '0; wr_data = '0; lock_pin = 1'b0; busy_in = 1'b0;
    m_we = 0; m_rwe = 0; m_lock = 0; m_rst = 0; m_wd = 0; m_bp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    check("R1 reset value", {wr_ack, nv_start, reg_rd}, 10'h000);

    put(0, 1, 15'h0100, 8'h55, "R2 array without write latch");
    put(1, 1, 15'h0, 8'h02, "R3 set write latch 02h");
    put(0, 1, 15'h7FFF, 8'hA5, "R7 unguarded top address");
    put(1, 1, 15'h0, 8'h06, "R3 set both latches 06h");
    put(1, 1, 15'h0, 8'h06, "R5 repeated 06h keeps fields");
    put(1, 1, 15'h0, 8'h9B, "R4 load lock=1 wd=00 bp=11 rst=1");
    put(1, 1, 15'h0, 8'h06, "R3 rearm");
    put(0, 1, 15'h0000, 8'h11, "R7 full guard refuses, clears step latch");
    @(negedge clk); lock_pin = 1'b1;
    put(1, 1, 15'h0, 8'h06, "R3 rearm under lock");
    put(1, 1, 15'h0, 8'h23, "R8 lock keeps lock-enable and protect");
    @(negedge clk); lock_pin = 1'b0;
    put(1, 1, 15'h0, 8'h06, "R3 rearm unlocked");
    put(1, 1, 15'h0, 8'h2B, "R4 load bp=01 unlocked");
    put(0, 1, 15'h5FFF, 8'h22, "R7 quarter guard below boundary");
    put(0, 1, 15'h6000, 8'h22, "R7 quarter guard at boundary");
    put(1, 1, 15'h0, 8'h06, "R3 rearm");
    put(1, 1, 15'h0, 8'h32, "R4 load bp=10");
    put(0, 1, 15'h3FFF, 8'h33, "R7 half guard below boundary");
    put(0, 1, 15'h4000, 8'h33, "R7 half guard at boundary");
    @(negedge clk); busy_in = 1'b1;
    put(1, 1, 15'h0, 8'h06, "R10 register byte while busy");
    put(0, 1, 15'h0010, 8'h44, "R10 array byte while busy");
    @(negedge clk); busy_in = 1'b0;
    put(1, 0, 15'h0, 8'h06, "R9 second register byte");
    put(1, 1, 15'h0, 8'h04, "R6 clear latches");
    put(0, 1, 15'h0010, 8'h66, "R2 array after latch cleared");
    put(1, 1, 15'h0, 8'h02, "R3 set write latch");
    put(1, 1, 15'h0, 8'h06, "R3 set step latch");
    put(1, 1, 15'h0, 8'h02, "R4 02h zeroes the fields");
    repeat (4) @(negedge clk);
    done = 1;
    if (q_due.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL R11: actual %0d pending results expected 0", q_due.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule